// File: doc/BRIEF.md
# Maskable Prioritized Interrupt Controller

This block collects six interrupt request levels for a small 8-bit microcontroller core and presents one of them to the core at a time. Four levels come from external port pins. A falling edge on a pin is captured and then synchronized to the internal clock, so every pin event reaches its request bit after a fixed number of clocks. The other two levels come from one-cycle pulses that internal peripherals, such as timers or serial logic, raise directly in the clock domain.

Software reaches three byte-wide registers on a simple register bus: a pending-request register, an enable register and an ordering register. The enable register holds one enable bit per level and a master enable. Two dedicated commands set and clear the master enable. A level is eligible when its request, its enable bit and the master enable are all 1. Among the eligible levels, the one that ranks highest in the ordering selected by software drives the interrupt line and the vector index.

When the core acknowledges, the block clears the granted request and the master enable. Polled handling works with the master enable off: requests still accumulate and software can read them and clear them.

Top module: `prio_intc`

## Requirements
- R1: While reset is asserted and after it is released (release takes effect two clocks later), the pending register reads 0x00, the master enable (enable register bit 7) reads 0 and irq_o is low.
- R2: Register reads are combinational from bus_addr_i. 0xF9 returns the ordering select in bits 2:0. 0xFA returns the pending levels in bits 5:0. 0xFB returns the per-level enables in bits 5:0 and the master enable in bit 7. All unused bits read 0. Any other address reads 0x00, and a write to it changes nothing.
- R3: gie_set_i sets the master enable and gie_clr_i clears it. When both are asserted, clear wins, and both override a bus write of bit 7 at 0xFB. While the master enable is 0, irq_o stays low.
- R4: A falling edge on port_pin_i[2], [3], [1] or [0] sets request level 0, 1, 2 or 3 respectively. If the edge is first sampled low at rising clock edge k, the bit is set at edge k+4. Rising edges and steady levels set nothing.
- R5: A high int_evt_i[0] or int_evt_i[1] at a rising edge sets request level 4 or 5 respectively at that edge.
- R6: irq_o is 1 exactly when some level has its request bit, its enable bit and the master enable all at 1.
- R7: The ordering select chooses the priority order, highest first. 0 gives 0,1,2,3,4,5 and 1 gives 5,4,3,2,1,0. A value s from 2 to 6 gives the ascending order rotated to start at level s-1. 7 gives 0,2,4,1,3,5.
- R8: irq_vec_o equals the number of the granted level while irq_o is 1, and 0 while irq_o is 0.
- R9: irq_ack_i while irq_o is 1 clears the granted request bit and the master enable at that edge. irq_ack_i while irq_o is 0 changes nothing.
- R10: A bus write to 0xFA loads bits 5:0 into the pending register. A hardware set of a bit at the same edge wins over the written value for that bit.
- R11: With the master enable at 0, hardware requests are still recorded and can be read at 0xFA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| port_pin_i | input | N_PIN (4) | External pins, falling-edge triggered |
| int_evt_i | input | N_INT (2) | Internal request pulses, levels 4 and 5 |
| bus_addr_i | input | 8 | Register bus address |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_rdata_o | output | 8 | Register bus read data, combinational from the address |
| gie_set_i | input | 1 | Enable command, sets the master enable |
| gie_clr_i | input | 1 | Disable command, clears the master enable |
| irq_ack_i | input | 1 | Core acknowledge of the presented interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 3 | Index of the granted level |

## Verification
The bench builds the block with its defaults: four pins, two internal sources, two synchronizer stages and two reset stages. These values give a pin-to-request latency of exactly four clocks, which the bench checks edge by edge. They also give six levels, so all eight ordering selects, including the rotations that wrap from level 5 back to 0 and the interleaved order, can be checked against a whole pending set and against that set with its top level removed. Random traffic then collides acknowledges, software writes, enable commands and pin edges in the same cycles.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int unsigned BUS_W       = 8;
  localparam int unsigned ORD_W       = 3;
  localparam int unsigned MASTER_POS  = 7;

  localparam logic [BUS_W-1:0] REG_ORDER_ADDR = 8'hF9;
  localparam logic [BUS_W-1:0] REG_PEND_ADDR  = 8'hFA;
  localparam logic [BUS_W-1:0] REG_ENA_ADDR   = 8'hFB;

  // Position (0 = highest) of level lvl among n levels under ordering sel.
  function automatic int order_rank(input logic [ORD_W-1:0] sel, input int lvl, input int n);
    int start;
    case (sel)
      3'd0:    order_rank = lvl;
      3'd1:    order_rank = n - 1 - lvl;
      3'd7:    order_rank = (lvl % 2 == 0) ? lvl / 2 : (n + 1) / 2 + lvl / 2;
      default: begin
        start      = (int'(sel) - 1) % n;
        order_rank = (lvl + n - start) % n;
      end
    endcase
  endfunction

  // Which pin feeds a pin-driven level.
  function automatic int pin_for_level(input int lvl);
    case (lvl)
      0:       pin_for_level = 2;
      1:       pin_for_level = 3;
      2:       pin_for_level = 1;
      default: pin_for_level = 0;
    endcase
  endfunction

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/intc_edge_sync.sv
module intc_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic evt_o
);

  logic smp_q,  smp_d;
  logic hist_q, hist_d;
  logic cap_q,  cap_d;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;

  // sample the pin, remember the previous sample, flag a high-to-low step
  always_comb begin
    smp_d  = pin_i;
    hist_d = smp_q;
    cap_d  = hist_q & ~smp_q;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = cap_q;
    end else begin : g_chain
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], cap_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b1;
      hist_q <= 1'b1;
      cap_q  <= 1'b0;
      sync_q <= '0;
    end else begin
      smp_q  <= smp_d;
      hist_q <= hist_d;
      cap_q  <= cap_d;
      sync_q <= sync_d;
    end
  end

  assign evt_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_LVL = 6,
  parameter int unsigned VEC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [N_LVL-1:0] hw_set_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             ack_fire_i,
  input  logic [VEC_W-1:0] ack_lvl_i,
  output logic [N_LVL-1:0] req_o,
  output logic [N_LVL-1:0] mask_o,
  output logic             gie_o,
  output logic [ORD_W-1:0] order_o,
  output logic [BUS_W-1:0] rdata_o
);

  logic [N_LVL-1:0] req_q, req_d;
  logic [N_LVL-1:0] mask_q;
  logic [ORD_W-1:0] order_q;
  logic             gie_q, gie_d;
  logic             wr_pend, wr_ena, wr_order;
  logic             req_en, gie_en;
  logic             unused_wbits;

  assign unused_wbits = ^wdata_i[BUS_W-2:N_LVL];

  always_comb begin
    wr_pend  = wr_en_i && (addr_i == REG_PEND_ADDR);
    wr_ena   = wr_en_i && (addr_i == REG_ENA_ADDR);
    wr_order = wr_en_i && (addr_i == REG_ORDER_ADDR);
  end

  // pending: software load, then acknowledge clear, then hardware set on top
  always_comb begin
    req_d = wr_pend ? wdata_i[N_LVL-1:0] : req_q;
    if (ack_fire_i) req_d[ack_lvl_i] = 1'b0;
    req_d  = req_d | hw_set_i;
    req_en = wr_pend | ack_fire_i | (|hw_set_i);
  end

  // master enable: disable or acknowledge beat enable, enable beats bus write
  always_comb begin
    if (gie_clr_i || ack_fire_i) gie_d = 1'b0;
    else if (gie_set_i)          gie_d = 1'b1;
    else if (wr_ena)             gie_d = wdata_i[MASTER_POS];
    else                         gie_d = gie_q;
    gie_en = gie_clr_i | ack_fire_i | gie_set_i | wr_ena;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_en) gie_q <= gie_d;
  end

  // level enables and ordering are left unreset
  always_ff @(posedge clk) begin
    if (wr_ena) mask_q <= wdata_i[N_LVL-1:0];
  end

  always_ff @(posedge clk) begin
    if (wr_order) order_q <= wdata_i[ORD_W-1:0];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_ORDER_ADDR: rdata_o[ORD_W-1:0] = order_q;
      REG_PEND_ADDR:  rdata_o[N_LVL-1:0] = req_q;
      REG_ENA_ADDR: begin
        rdata_o[N_LVL-1:0]  = mask_q;
        rdata_o[MASTER_POS] = gie_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign req_o   = req_q;
  assign mask_o  = mask_q;
  assign gie_o   = gie_q;
  assign order_o = order_q;

endmodule

// File: rtl/intc_select.sv
module intc_select
  import intc_pkg::*;
#(
  parameter int unsigned N_LVL = 6,
  parameter int unsigned VEC_W = 3
) (
  input  logic [N_LVL-1:0] req_i,
  input  logic [N_LVL-1:0] mask_i,
  input  logic             gie_i,
  input  logic [ORD_W-1:0] order_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o
);

  localparam int unsigned RANK_W = (N_LVL > 1) ? $clog2(N_LVL) : 1;

  logic [N_LVL-1:0]  elig;
  logic [RANK_W-1:0] rank_w [N_LVL];
  logic [RANK_W-1:0] best;
  logic              found;

  assign elig = req_i & mask_i & {N_LVL{gie_i}};

  generate
    for (genvar g = 0; g < int'(N_LVL); g++) begin : g_rank
      assign rank_w[g] = RANK_W'(order_rank(order_i, g, int'(N_LVL)));
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    best  = '0;
    vec_o = '0;
    for (int i = 0; i < int'(N_LVL); i++) begin
      if (elig[i] && (!found || rank_w[i] < best)) begin
        found = 1'b1;
        best  = rank_w[i];
        vec_o = VEC_W'(i);
      end
    end
    irq_o = found;
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int unsigned N_PIN       = 4,
  parameter int unsigned N_INT       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [N_PIN-1:0]                   port_pin_i,
  input  logic [N_INT-1:0]                   int_evt_i,
  input  logic [7:0]                         bus_addr_i,
  input  logic [7:0]                         bus_wdata_i,
  input  logic                               bus_we_i,
  output logic [7:0]                         bus_rdata_o,
  input  logic                               gie_set_i,
  input  logic                               gie_clr_i,
  input  logic                               irq_ack_i,
  output logic                               irq_o,
  output logic [$clog2(N_PIN+N_INT)-1:0]     irq_vec_o
);

  localparam int unsigned N_LVL = N_PIN + N_INT;
  localparam int unsigned VEC_W = $clog2(N_LVL);

  logic             rst_sync_n;
  logic [N_PIN-1:0] pin_evt;
  logic [N_LVL-1:0] hw_set;
  logic [N_LVL-1:0] req_q, mask_q;
  logic             gie_q;
  logic [ORD_W-1:0] order_q;
  logic             ack_fire;

  intc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  generate
    for (genvar p = 0; p < int'(N_PIN); p++) begin : g_pin
      intc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .pin_i (port_pin_i[p]),
        .evt_o (pin_evt[p])
      );
    end
    for (genvar l = 0; l < int'(N_PIN); l++) begin : g_map
      assign hw_set[l] = pin_evt[pin_for_level(l)];
    end
  endgenerate

  assign hw_set[N_LVL-1:N_PIN] = int_evt_i;
  assign ack_fire = irq_ack_i & irq_o;

  intc_regs #(.N_LVL(N_LVL), .VEC_W(VEC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en_i    (bus_we_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .hw_set_i   (hw_set),
    .gie_set_i  (gie_set_i),
    .gie_clr_i  (gie_clr_i),
    .ack_fire_i (ack_fire),
    .ack_lvl_i  (irq_vec_o),
    .req_o      (req_q),
    .mask_o     (mask_q),
    .gie_o      (gie_q),
    .order_o    (order_q),
    .rdata_o    (bus_rdata_o)
  );

  intc_select #(.N_LVL(N_LVL), .VEC_W(VEC_W)) u_select (
    .req_i   (req_q),
    .mask_i  (mask_q),
    .gie_i   (gie_q),
    .order_i (order_q),
    .irq_o   (irq_o),
    .vec_o   (irq_vec_o)
  );

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int unsigned N_LVL = 6,
  parameter int unsigned VEC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_o,
  input logic             irq_ack_i,
  input logic             gie_clr_i,
  input logic             gie_q,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [N_LVL-1:0] req_q,
  input logic [N_LVL-1:0] mask_q,
  input logic [N_LVL-1:0] hw_set
);

  logic [VEC_W-1:0] vec_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_hold_q <= '0;
    else        vec_hold_q <= irq_vec_o;
  end

  // R6
  irq_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> gie_q);

  // R8
  vec_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (req_q[irq_vec_o] && mask_q[irq_vec_o]));

  // R8
  vec_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_vec_o == '0));

  // R9
  ack_drops_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_o) |=> !gie_q);

  // R9
  ack_clears_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_o && !hw_set[irq_vec_o]) |=> !req_q[vec_hold_q]);

  // R3
  disable_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr_i |=> !irq_o);

  // R10
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((req_q & $past(hw_set)) == $past(hw_set)));

endmodule

bind prio_intc prio_intc_chk #(.N_LVL(N_LVL), .VEC_W(VEC_W)) u_prio_intc_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .irq_o     (irq_o),
  .irq_ack_i (irq_ack_i),
  .gie_clr_i (gie_clr_i),
  .gie_q     (gie_q),
  .irq_vec_o (irq_vec_o),
  .req_q     (req_q),
  .mask_q    (mask_q),
  .hw_set    (hw_set)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  localparam int N_RAND     = 3000;
  localparam int WATCHDOG   = 20000;
  localparam int PIN_OF [4] = '{2, 3, 1, 0};

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] port_pin;
  logic [1:0] int_evt;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic       bus_we, gie_set, gie_clr, irq_ack, irq;
  logic [2:0] irq_vec;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [5:0]     m_req, m_mask;
  logic           m_gie;
  logic [2:0]     m_order;
  logic [3:0]     m_smp;
  logic [LAT-1:0] m_dly [4];
  bit             cfg_ok = 0;
  logic [3:0]     cur_pins;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc i_prio_intc (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_pin_i  (port_pin),
    .int_evt_i   (int_evt),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_we_i    (bus_we),
    .bus_rdata_o (bus_rdata),
    .gie_set_i   (gie_set),
    .gie_clr_i   (gie_clr),
    .irq_ack_i   (irq_ack),
    .irq_o       (irq),
    .irq_vec_o   (irq_vec)
  );

  function automatic int lvl_at(input logic [2:0] e, input int p);
    case (e)
      3'd0:    return p;
      3'd1:    return 5 - p;
      3'd7:    return (p < 3) ? 2 * p : 2 * (p - 3) + 1;
      default: return (p + int'(e) - 1) % 6;
    endcase
  endfunction

  function automatic int exp_pick(input logic [5:0] rq, input logic [5:0] mk,
                                  input logic g, input logic [2:0] e);
    if (!g) return -1;
    for (int p = 0; p < 6; p++) begin
      int l;
      l = lvl_at(e, p);
      if (rq[l] && mk[l]) return l;
    end
    return -1;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [7:0] a);
    case (a)
      8'hF9:   return {5'b0, m_order};
      8'hFA:   return {2'b0, m_req};
      8'hFB:   return {m_gie, 1'b0, m_mask};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: drive after a falling edge, compare, advance the model at the rising edge
  task automatic cycle(input logic [3:0] pins, input logic [1:0] evt, input logic we,
                       input logic [7:0] addr, input logic [7:0] wd,
                       input logic gset, input logic gclr, input logic ack);
    int         pick;
    logic [5:0] hw, nreq;
    port_pin  = pins;  int_evt = evt;  bus_we  = we;   bus_addr = addr;
    bus_wdata = wd;    gie_set = gset; gie_clr = gclr; irq_ack  = ack;
    cur_pins  = pins;
    #1;
    pick = exp_pick(m_req, m_mask, m_gie, m_order);
    chk("R6 irq_o", int'(irq), int'(pick >= 0));
    chk("R8 irq_vec_o", int'(irq_vec), (pick >= 0) ? pick : 0);
    if (cfg_ok || addr == 8'hFA) chk("R2 bus_rdata_o", int'(bus_rdata), int'(exp_rdata(addr)));
    @(posedge clk);
    hw = '0;
    for (int l = 0; l < 4; l++) begin
      hw[l]    = m_dly[l][LAT-1];
      m_dly[l] = {m_dly[l][LAT-2:0], m_smp[PIN_OF[l]] & ~pins[PIN_OF[l]]};
    end
    m_smp   = pins;
    hw[5:4] = evt;
    nreq = (we && addr == 8'hFA) ? wd[5:0] : m_req;
    if (ack && pick >= 0) nreq[pick] = 1'b0;
    m_req = nreq | hw;
    if (gclr || (ack && pick >= 0)) m_gie = 1'b0;
    else if (gset)                  m_gie = 1'b1;
    else if (we && addr == 8'hFB)   m_gie = wd[7];
    if (we && addr == 8'hFB) m_mask  = wd[5:0];
    if (we && addr == 8'hF9) m_order = wd[2:0];
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] wd);
    cycle(cur_pins, 2'b00, 1'b1, addr, wd, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input logic [7:0] addr);
    cycle(cur_pins, 2'b00, 1'b0, addr, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; port_pin = 4'hF; int_evt = '0; bus_we = 0; bus_addr = 8'hFA;
    bus_wdata = '0; gie_set = 0; gie_clr = 0; irq_ack = 0; cur_pins = 4'hF;
    m_req = '0; m_mask = '0; m_gie = 0; m_order = '0; m_smp = 4'hF;
    for (int l = 0; l < 4; l++) m_dly[l] = '0;

    // R1 during reset
    repeat (3) @(negedge clk);
    chk("R1 pending in reset", int'(bus_rdata), 0);
    chk("R1 irq_o in reset", int'(irq), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_addr = 8'hFA; #1;
    chk("R1 pending after release", int'(bus_rdata), 0);
    bus_addr = 8'hFB; #1;
    chk("R1 master enable after release", int'(bus_rdata[7]), 0);
    chk("R1 irq_o after release", int'(irq), 0);
    @(negedge clk);

    wr(8'hFB, 8'h3F);
    wr(8'hF9, 8'h00);
    cfg_ok = 1;

    // R11 polled accumulation with master off
    cycle(4'hF, 2'b01, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R11 polled pending read", int'(bus_rdata), 8'h10);
    chk("R11 no irq with master off", int'(irq), 0);
    wr(8'hFA, 8'h00);

    // R4 latency on pin 2 -> level 0
    for (int j = 0; j <= LAT; j++) begin
      cycle(4'hB, 2'b00, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
      chk("R4 edge to request latency", int'(bus_rdata[0]), int'(j == LAT));
    end
    // R4 pins 3,1,0 -> levels 1,2,3
    repeat (LAT + 1) cycle(4'h0, 2'b00, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R4 pin to level mapping", int'(bus_rdata), 8'h0F);
    wr(8'hFA, 8'h00);
    repeat (LAT + 2) cycle(4'hF, 2'b00, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R4 rising edge ignored", int'(bus_rdata), 0);

    // R7 orderings
    wr(8'hFA, 8'h3F);
    cycle(4'hF, 2'b00, 1'b0, 8'hFA, 8'h00, 1'b1, 1'b0, 1'b0);
    for (int e = 0; e < 8; e++) begin
      wr(8'hF9, 8'(e));
      chk("R7 top of ordering", int'(irq_vec), lvl_at(3'(e), 0));
      wr(8'hFA, 8'h3F & ~(8'h01 << lvl_at(3'(e), 0)));
      chk("R7 second in ordering", int'(irq_vec), lvl_at(3'(e), 1));
      wr(8'hFA, 8'h3F);
    end

    // R9 acknowledge (ordering 7, top level 0)
    cycle(4'hF, 2'b00, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R9 granted bit cleared", int'(bus_rdata), 8'h3E);
    chk("R9 master cleared by ack", int'(irq), 0);
    cycle(4'hF, 2'b00, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R9 ack without irq ignored", int'(bus_rdata), 8'h3E);

    // R10 hardware set beats software write
    cycle(4'hF, 2'b01, 1'b1, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R10 hw set wins over write", int'(bus_rdata), 8'h10);

    // R3 enable commands
    cycle(4'hF, 2'b00, 1'b0, 8'hFB, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R3 disable beats enable", int'(bus_rdata[7]), 0);
    cycle(4'hF, 2'b00, 1'b0, 8'hFB, 8'h00, 1'b1, 1'b0, 1'b0);
    chk("R3 enable command sets", int'(bus_rdata[7]), 1);
    chk("R6 irq with eligible level", int'(irq), 1);
    cycle(4'hF, 2'b00, 1'b1, 8'hFB, 8'hBF, 1'b0, 1'b1, 1'b0);
    chk("R3 disable beats bus write", int'(bus_rdata[7]), 0);
    chk("R3 irq low with master off", int'(irq), 0);

    // R5 internal pulse to level 5
    wr(8'hFA, 8'h00);
    cycle(4'hF, 2'b10, 1'b0, 8'hFA, 8'h00, 1'b0, 1'b0, 1'b0);
    chk("R5 internal pulse sets level 5", int'(bus_rdata), 8'h20);

    // R6 masking, R8 vector
    wr(8'hFB, 8'h9F);
    chk("R6 masked level gives no irq", int'(irq), 0);
    wr(8'hFB, 8'hBF);
    chk("R6 unmasked level raises irq", int'(irq), 1);
    chk("R8 vector of granted level", int'(irq_vec), 5);

    // R2 unused address
    wr(8'h42, 8'hFF);
    chk("R2 unused address reads zero", int'(bus_rdata), 0);

    // random traffic
    for (int n = 0; n < N_RAND; n++) begin
      logic [3:0] pins;
      logic [1:0] evt;
      logic [7:0] addr;
      logic [7:0] addr_set [4];
      addr_set = '{8'hF9, 8'hFA, 8'hFB, 8'h42};
      pins = cur_pins;
      for (int b = 0; b < 4; b++) if ($urandom % 6 == 0) pins[b] = ~pins[b];
      evt  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      addr = addr_set[$urandom % 4];
      cycle(pins, evt, ($urandom % 5 == 0), addr, 8'($urandom),
            ($urandom % 6 == 0), ($urandom % 25 == 0), ($urandom % 3 == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule